// File: doc/BRIEF.md
# PWM Controller Global Register Block

This block is the shared register front end of a four-channel pulse-width modulator. It sits on a simple word-addressed register bus and holds a free-form mode word, the per-channel run enables and the per-channel period interrupt logic. It drives the enable vector to the channel counters and a single interrupt line. Run enables and interrupt mask bits are never written directly. One register sets bits where the written word has ones, and a second register clears bits where the written word has ones. Pending interrupt flags are acknowledged by reading them.

Above the global registers, the address space holds one fixed-stride window per channel. The block decodes which window an access falls in and presents a one-hot channel select and a word index to the channel slices. Read data from the selected slice is returned on the shared read bus. The bus port is plain control: a request is accepted in the cycle it is presented, with no back-pressure. Read data comes back, registered, together with a valid strobe in the following cycle.

Top module: `pwm_gctl`

## Requirements
- R1: Reset clears the run enables, the interrupt mask, the pending flags and the mode word, so `chan_en` and `irq` are 0 after reset.
- R2: A write to byte offset 0x04 sets run enable n for each bit n of the data that is 1. Zero bits leave channels unchanged, and bits at or above the channel count are ignored. `chan_en` shows the new value one cycle after the write.
- R3: A write to byte offset 0x08 clears run enable n for each bit n of the data that is 1. Zero bits leave channels unchanged.
- R4: A read of offset 0x0C returns the run-enable vector in bits [NCH-1:0], with zeros above.
- R5: Writes to offset 0x10 set mask bits, and writes to offset 0x14 clear mask bits, each using one bit per channel. A read of offset 0x18 returns the mask.
- R6: A one-cycle pulse on `period_end[n]` sets pending flag n. The flag stays set until it is acknowledged.
- R7: A read of offset 0x1C returns the pending flags as they stood before the access and clears all of them. A period-end pulse in the same cycle as this read leaves its flag set.
- R8: `irq` is 1 exactly when some pending flag has its mask bit set. It follows the registered state, one cycle after the event or acknowledgement.
- R9: Offset 0x00 is a 32-bit mode word that can be read and written.
- R10: An access whose address lies in [0x200 + n*0x20, 0x200 + n*0x20 + 0x1F], for n below the channel count, drives `chan_sel` one-hot with bit n set. It also drives `chan_word` = address bits [4:2] combinationally. A read there returns bits [32n+31:32n] of `chan_rdata`.
- R11: Every read request produces `bus_rvalid` and its data exactly one cycle later. Unmapped addresses and the write-only offsets 0x04, 0x08, 0x10 and 0x14 read as 0. Writes to offsets 0x0C, 0x18 and 0x1C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (12) | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read request |
| chan_sel | output | NCH (4) | One-hot channel window select |
| chan_word | output | 3 | Word index inside the channel window |
| chan_rdata | input | NCH*32 (128) | Read data from the channel slices, packed by channel |
| period_end | input | NCH (4) | Per-channel end-of-period pulse |
| chan_en | output | NCH (4) | Run enable per channel |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the acknowledge race. A period-end pulse lands in the same cycle as a pending-register read, so the read must return the old flags and the flag must survive the clear. A design that cleared after merging would lose that interrupt for good. It also writes words with all high bits set to the set register, and tries writes to read-only offsets. A design that stored or honoured those bits would enable absent channels or corrupt the enable and mask state. Masked versus unmasked events check that `irq` does not fire for masked channels. Addresses at both edges of a channel window and just past the last window check the decoder's off-by-one behaviour.

// File: rtl/pwm_gctl_pkg.sv
package pwm_gctl_pkg;

  // Word index of each global register (byte offset = index * 4)
  typedef enum logic [2:0] {
    G_MODE  = 3'd0,
    G_SET   = 3'd1,
    G_CLR   = 3'd2,
    G_RUN   = 3'd3,
    G_MSET  = 3'd4,
    G_MCLR  = 3'd5,
    G_MASK  = 3'd6,
    G_PEND  = 3'd7
  } greg_e;

  localparam int unsigned DW = 32;

endpackage

// File: rtl/pwm_addr_decode.sv
module pwm_addr_decode
  import pwm_gctl_pkg::*;
#(
  parameter int unsigned AW        = 12,
  parameter int unsigned NCH       = 4,
  parameter int unsigned WIN_BASE  = 'h200,
  parameter int unsigned STRIDE_LG = 5,
  localparam int unsigned IDX_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                   req,
  input  logic [AW-1:0]          addr,
  output logic                   g_hit,
  output greg_e                  g_reg,
  output logic [NCH-1:0]         sel,
  output logic [STRIDE_LG-3:0]   word,
  output logic                   ch_hit,
  output logic [IDX_W-1:0]       ch_idx
);

  // global registers occupy the first eight words
  assign g_hit = req && ((addr >> 5) == '0);
  assign g_reg = greg_e'(addr[4:2]);
  assign word  = addr[STRIDE_LG-1:2];

  for (genvar n = 0; n < NCH; n++) begin : g_win
    localparam logic [AW-1:0] BLK = AW'((WIN_BASE >> STRIDE_LG) + n);
    assign sel[n] = req && ((addr >> STRIDE_LG) == BLK);
  end

  assign ch_hit = |sel;

  always_comb begin
    ch_idx = '0;
    for (int n = 0; n < NCH; n++)
      if (sel[n]) ch_idx = IDX_W'(n);
  end

endmodule

// File: rtl/pwm_w1sc_reg.sv
module pwm_w1sc_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (set_we) q <= q | bits;
    else if (clr_we) q <= q & ~bits;
  end

endmodule

// File: rtl/pwm_pend_flags.sv
module pwm_pend_flags #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         ack,
  output logic [W-1:0] q
);

  // acknowledge drops old flags, but a fresh event always lands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (ack ? '0 : q) | evt;
  end

endmodule

// File: rtl/pwm_gctl.sv
module pwm_gctl
  import pwm_gctl_pkg::*;
#(
  parameter int unsigned NCH       = 4,
  parameter int unsigned AW        = 12,
  parameter int unsigned WIN_BASE  = 'h200,
  parameter int unsigned STRIDE_LG = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_req,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic                 bus_rvalid,
  output logic [NCH-1:0]       chan_sel,
  output logic [STRIDE_LG-3:0] chan_word,
  input  logic [NCH*DW-1:0]    chan_rdata,
  input  logic [NCH-1:0]       period_end,
  output logic [NCH-1:0]       chan_en,
  output logic                 irq
);

  localparam int unsigned IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic             g_hit, ch_hit;
  greg_e            g_reg;
  logic [IDX_W-1:0] ch_idx;
  logic             g_wr, g_rd;
  logic [NCH-1:0]   mask_q, pend_q;
  logic [DW-1:0]    mode_q, rd_mux;

  pwm_addr_decode #(
    .AW(AW), .NCH(NCH), .WIN_BASE(WIN_BASE), .STRIDE_LG(STRIDE_LG)
  ) u_dec (
    .req(bus_req), .addr(bus_addr), .g_hit(g_hit), .g_reg(g_reg),
    .sel(chan_sel), .word(chan_word), .ch_hit(ch_hit), .ch_idx(ch_idx)
  );

  assign g_wr = g_hit && bus_wr;
  assign g_rd = g_hit && !bus_wr;

  pwm_w1sc_reg #(.W(NCH)) u_run (
    .clk(clk), .rst_n(rst_n),
    .set_we(g_wr && g_reg == G_SET), .clr_we(g_wr && g_reg == G_CLR),
    .bits(bus_wdata[NCH-1:0]), .q(chan_en)
  );

  pwm_w1sc_reg #(.W(NCH)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .set_we(g_wr && g_reg == G_MSET), .clr_we(g_wr && g_reg == G_MCLR),
    .bits(bus_wdata[NCH-1:0]), .q(mask_q)
  );

  pwm_pend_flags #(.W(NCH)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(period_end),
    .ack(g_rd && g_reg == G_PEND), .q(pend_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       mode_q <= '0;
    else if (g_wr && g_reg == G_MODE) mode_q <= bus_wdata;
  end

  assign irq = |(pend_q & mask_q);

  always_comb begin
    rd_mux = '0;
    if (g_hit) begin
      unique case (g_reg)
        G_MODE:  rd_mux = mode_q;
        G_RUN:   rd_mux = DW'(chan_en);
        G_MASK:  rd_mux = DW'(mask_q);
        G_PEND:  rd_mux = DW'(pend_q);
        default: rd_mux = '0;
      endcase
    end else if (ch_hit) begin
      rd_mux = chan_rdata[ch_idx*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_req && !bus_wr;
      if (bus_req && !bus_wr) bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/pwm_gctl_chk.sv
module pwm_gctl_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_req,
  input logic           bus_wr,
  input logic [AW-1:0]  bus_addr,
  input logic [31:0]    bus_wdata,
  input logic           bus_rvalid,
  input logic [NCH-1:0] chan_sel,
  input logic [NCH-1:0] period_end,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] mask_q,
  input logic           irq
);

  logic wr_set, wr_clr, rd_pend;
  assign wr_set  = bus_req && bus_wr && bus_addr[AW-1:2] == (AW-2)'(1);
  assign wr_clr  = bus_req && bus_wr && bus_addr[AW-1:2] == (AW-2)'(2);
  assign rd_pend = bus_req && !bus_wr && bus_addr[AW-1:2] == (AW-2)'(7);

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (chan_en == '0 && !irq));

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((chan_en & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(chan_en));

  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((chan_en & $past(bus_wdata[NCH-1:0])) == '0));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && period_end == '0) |=> !irq);

  assert_masked_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((period_end & mask_q) != '0) |=> irq);

  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_sel));

  assert_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr) |=> bus_rvalid);

  assert_no_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_wr) |=> !bus_rvalid);

endmodule

bind pwm_gctl pwm_gctl_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .chan_sel(chan_sel), .period_end(period_end), .chan_en(chan_en),
  .mask_q(mask_q), .irq(irq)
);

// File: tb/test_pwm_gctl.sv
`timescale 1ns/1ps
module test_pwm_gctl;

  localparam int NCH = 4;
  localparam int AW  = 12;
  localparam int NV  = 17;

  // {is_write, addr, wdata, expected read data}
  localparam logic [76:0] VECS [NV] = '{
    {1'b1, 12'h000, 32'hA5A51234, 32'h0},         // R9 mode write
    {1'b0, 12'h000, 32'h0, 32'hA5A51234},         // R9
    {1'b1, 12'h004, 32'hFFFFFFF5, 32'h0},         // R2 high bits ignored
    {1'b0, 12'h00C, 32'h0, 32'h5},                // R2 R4
    {1'b1, 12'h004, 32'h2, 32'h0},                // R2
    {1'b0, 12'h00C, 32'h0, 32'h7},                // R2 zeros unchanged
    {1'b1, 12'h008, 32'h5, 32'h0},                // R3
    {1'b0, 12'h00C, 32'h0, 32'h2},                // R3
    {1'b1, 12'h00C, 32'hF, 32'h0},                // R11 read-only write
    {1'b0, 12'h00C, 32'h0, 32'h2},                // R11
    {1'b1, 12'h010, 32'h9, 32'h0},                // R5
    {1'b0, 12'h018, 32'h0, 32'h9},                // R5
    {1'b1, 12'h014, 32'h1, 32'h0},                // R5
    {1'b0, 12'h018, 32'h0, 32'h8},                // R5
    {1'b0, 12'h004, 32'h0, 32'h0},                // R11 write-only reads 0
    {1'b0, 12'h100, 32'h0, 32'h0},                // R11 unmapped
    {1'b0, 12'h01C, 32'h0, 32'h0}                 // R7 nothing pending
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_req = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              bus_rvalid;
  logic [NCH-1:0]    chan_sel;
  logic [2:0]        chan_word;
  logic [NCH*32-1:0] chan_rdata;
  logic [NCH-1:0]    period_end = '0;
  logic [NCH-1:0]    chan_en;
  logic              irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  for (genvar n = 0; n < NCH; n++) begin : g_cd
    assign chan_rdata[n*32 +: 32] = 32'hC0DE0000 + n;
  end

  pwm_gctl i_pwm_gctl (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .chan_sel(chan_sel), .chan_word(chan_word),
    .chan_rdata(chan_rdata), .period_end(period_end), .chan_en(chan_en),
    .irq(irq)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // one access; returns at the falling edge after the capturing edge
  task automatic bus_op(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                        input logic [NCH-1:0] pe);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d; period_end = pe;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0; period_end = '0;
  endtask

  task automatic rd_chk(input string rq, input logic [AW-1:0] a, input logic [31:0] exp);
    bus_op(1'b0, a, 32'h0, '0);
    chk({rq, " rvalid"}, 32'(bus_rvalid), 32'h1);
    chk(rq, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [NCH-1:0] pe);
    @(negedge clk); period_end = pe;
    @(negedge clk); period_end = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 chan_en at reset", 32'(chan_en), 32'h0);
    chk("R1 irq at reset", 32'(irq), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      bus_op(VECS[i][76], VECS[i][75:64], VECS[i][63:32], '0);
      if (!VECS[i][76]) begin
        chk($sformatf("vector %0d rvalid R11", i), 32'(bus_rvalid), 32'h1);
        chk($sformatf("vector %0d R2-R11 data", i), bus_rdata, VECS[i][31:0]);
      end
    end

    chk("R2 chan_en port", 32'(chan_en), 32'h2);

    // pending and interrupt, mask = 4'b1000
    pulse(4'b0010);
    chk("R8 masked event no irq", 32'(irq), 32'h0);
    pulse(4'b1000);
    chk("R8 unmasked event irq", 32'(irq), 32'h1);
    rd_chk("R6 pending flags", 12'h01C, 32'hA);
    chk("R7 irq after ack", 32'(irq), 32'h0);
    rd_chk("R7 cleared by read", 12'h01C, 32'h0);

    // event in the same cycle as the acknowledging read
    bus_op(1'b0, 12'h01C, 32'h0, 4'b0100);
    chk("R7 race read old value", bus_rdata, 32'h0);
    rd_chk("R7 race flag kept", 12'h01C, 32'h4);

    // channel window decode
    @(negedge clk); bus_req = 1'b1; bus_wr = 1'b0; bus_addr = 12'h240; #1;
    chk("R10 sel first word ch2", 32'(chan_sel), 32'h4);
    chk("R10 word first", 32'(chan_word), 32'h0);
    @(negedge clk); bus_addr = 12'h27C; #1;
    chk("R10 sel last word ch3", 32'(chan_sel), 32'h8);
    chk("R10 word last", 32'(chan_word), 32'h7);
    @(negedge clk); bus_addr = 12'h280; #1;
    chk("R10 past last window", 32'(chan_sel), 32'h0);
    @(negedge clk); bus_req = 1'b0;
    rd_chk("R10 channel read", 12'h264, 32'hC0DE0003);
    rd_chk("R10 channel0 read", 12'h200, 32'hC0DE0000);
    rd_chk("R11 below windows", 12'h1FC, 32'h0);

    // mid-run reset with an interrupt outstanding
    pulse(4'b1000);
    chk("R8 irq before reset", 32'(irq), 32'h1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 chan_en after reset", 32'(chan_en), 32'h0);
    chk("R1 irq after reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    rd_chk("R1 mode cleared", 12'h000, 32'h0);
    rd_chk("R1 mask cleared", 12'h018, 32'h0);
    rd_chk("R1 pending cleared", 12'h01C, 32'h0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule